// File: doc/BRIEF.md
# Multi-Channel Quadrature Position Counter

This block tracks the positions of up to sixteen incremental encoders whose two phase signals arrive on one wide input bus. Encoder pin pairs begin at a run-time bit offset and repeat at a fixed stride, so the board wiring can leave gaps between encoders. Each round, every active encoder's synchronized phase pair is compared with the pair from the previous round. A parallel decoder turns that comparison into a step of -1, 0 or +1 for each encoder.

A single shared adder then visits the active encoders in ascending order, one per cycle. It adds each step into that encoder's 32-bit signed position. Every new position is written out on a simple word-addressed write port with no back-pressure. A round takes one sampling cycle plus one cycle per active encoder.

Top module: `quad_pos_counter`

## Requirements
- R1: Encoder k reads phase A from bus bit `first_bit_i + k*STRIDE` and phase B from the bit above it. Bus bits outside the pairs of the active encoders have no effect on any position.
- R2: A single-phase change is a legal step. With gray index 0 = (A=0,B=0), 1 = (A=1,B=0), 2 = (A=1,B=1), 3 = (A=0,B=1), a move from index i to (i+1) mod 4 adds +1, and a move to (i+3) mod 4 adds -1. No change adds 0.
- R3: A move where both phases change between samples leaves the position unchanged. The internal step code is 00 for no count, 01 for +1 and 11 for -1, and it never takes the value 10.
- R4: Reset clears every position to zero. The first synchronized sample after reset becomes the previous state and produces no count, whatever the phase levels are.
- R5: Positions are 32-bit two's complement. A step of -1 taken from zero produces negative values (for example, 40 backward steps give 0xFFFFFFD8).
- R6: After each update, `wr_o` is high for one cycle. In that cycle `addr_o` = `base_addr_i` + 4*k and `data_o` holds the new position. Within a round, k runs 0, 1, …, `num_enc_i`-1 on consecutive cycles.
- R7: Between the write of the last active encoder and the next write of encoder 0 there is exactly one cycle without a write. Writes for a given encoder therefore repeat every `num_enc_i`+1 cycles.
- R8: With `num_enc_i` = 0, `wr_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_i | input | IN_W (96) | Raw phase inputs of all encoders |
| first_bit_i | input | $clog2(IN_W) (7) | Bus index of encoder 0 phase A |
| num_enc_i | input | $clog2(N_ENC+1) (5) | Number of active encoders, 0 to N_ENC |
| base_addr_i | input | AW (32) | Byte address of encoder 0's word |
| wr_o | output | 1 | Write strobe, one cycle per update |
| addr_o | output | AW (32) | Byte address of the word being written |
| data_o | output | PW (32) | New signed position |

## Verification
The bench walks every pair of previous and next gray states, including the illegal two-phase jumps, for each encoder. A design that counted illegal jumps, or that had the direction rule reversed, would drift away from the bench's arithmetic position. Unused bus bits are toggled on every change, so a wrong stride or a wrong offset would pick up noise as counts. Reset is released while all phases are high, which catches a design that counts its first sample. A long backward run checks that negative values are sign-extended. Write order, write spacing and the silent zero-encoder case are tracked on every strobe, so a skipped, repeated or extra write shows up as an address or period miscompare.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_UPDATE = 2'd2
  } qpc_state_e;

  // code: bit0 = count flag, bit1 = negative direction
  function automatic logic [1:0] step_code(input logic a1, input logic b1,
                                           input logic a2, input logic b2);
    logic cnt;
    cnt = a1 ^ a2 ^ b1 ^ b2;
    return cnt ? {a1 ^ b2, 1'b1} : 2'b00;
  endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode import qpc_pkg::*; #(
  parameter int N_ENC  = 16,
  parameter int STRIDE = 5,
  parameter int IN_W   = 96,
  localparam int SEL_W = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]    sync_i,
  input  logic [SEL_W-1:0]   first_i,
  input  logic [2*N_ENC-1:0] prev_i,
  output logic [2*N_ENC-1:0] cur_o,
  output logic [2*N_ENC-1:0] step_o
);
  logic [IN_W-1:0] aligned;
  assign aligned = sync_i >> first_i;

  for (genvar k = 0; k < N_ENC; k++) begin : g_enc
    localparam int APOS = k * STRIDE;
    if (APOS + 1 < IN_W) begin : g_pins
      assign cur_o[2*k]   = aligned[APOS];
      assign cur_o[2*k+1] = aligned[APOS+1];
    end else begin : g_none
      assign cur_o[2*k]   = 1'b0;
      assign cur_o[2*k+1] = 1'b0;
    end
    assign step_o[2*k +: 2] = step_code(prev_i[2*k], prev_i[2*k+1],
                                        cur_o[2*k], cur_o[2*k+1]);
  end
endmodule

// File: rtl/qpc_seq.sv
module qpc_seq import qpc_pkg::*; #(
  parameter int N_ENC  = 16,
  localparam int CNT_W = $clog2(N_ENC + 1),
  localparam int IDX_W = (N_ENC > 1) ? $clog2(N_ENC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] num_i,
  output logic             prime_o,
  output logic             capture_o,
  output logic             upd_o,
  output logic [IDX_W-1:0] idx_o
);
  qpc_state_e       state_q;
  logic [1:0]       init_q;
  logic [CNT_W-1:0] num_q;
  logic [CNT_W-1:0] num_c;
  logic             last_idx;

  assign num_c     = (num_i > CNT_W'(N_ENC)) ? CNT_W'(N_ENC) : num_i;
  assign last_idx  = (CNT_W'(idx_o) + CNT_W'(1)) == num_q;
  assign prime_o   = (state_q == ST_INIT) && (init_q == 2'd2);
  assign capture_o = (state_q == ST_SAMPLE);
  assign upd_o     = (state_q == ST_UPDATE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      init_q  <= 2'd0;
      num_q   <= '0;
      idx_o   <= '0;
    end else begin
      unique case (state_q)
        ST_INIT: begin
          // wait for the synchronizer to fill before priming
          if (init_q == 2'd2) state_q <= ST_SAMPLE;
          else                init_q  <= init_q + 2'd1;
        end
        ST_SAMPLE: begin
          num_q <= num_c;
          idx_o <= '0;
          if (num_c != '0) state_q <= ST_UPDATE;
        end
        ST_UPDATE: begin
          idx_o <= idx_o + IDX_W'(1);
          if (last_idx) state_q <= ST_SAMPLE;
        end
        default: state_q <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter import qpc_pkg::*; #(
  parameter int N_ENC  = 16,
  parameter int STRIDE = 5,
  parameter int IN_W   = 96,
  parameter int AW     = 32,
  parameter int PW     = 32,
  localparam int SEL_W = $clog2(IN_W),
  localparam int CNT_W = $clog2(N_ENC + 1),
  localparam int IDX_W = (N_ENC > 1) ? $clog2(N_ENC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  phase_i,
  input  logic [SEL_W-1:0] first_bit_i,
  input  logic [CNT_W-1:0] num_enc_i,
  input  logic [AW-1:0]    base_addr_i,
  output logic             wr_o,
  output logic [AW-1:0]    addr_o,
  output logic [PW-1:0]    data_o
);
  logic [IN_W-1:0]    phase_s;
  logic [2*N_ENC-1:0] cur_c, step_c, prev_q, step_q;
  logic               prime, capture, upd;
  logic [IDX_W-1:0]   idx;
  logic [PW-1:0]      pos_q [N_ENC];
  logic [1:0]         step_sel;
  logic [PW-1:0]      delta, sum;

  qpc_sync #(.W(IN_W)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (phase_i),
    .q_o   (phase_s)
  );

  qpc_decode #(.N_ENC(N_ENC), .STRIDE(STRIDE), .IN_W(IN_W)) i_decode (
    .sync_i (phase_s),
    .first_i(first_bit_i),
    .prev_i (prev_q),
    .cur_o  (cur_c),
    .step_o (step_c)
  );

  qpc_seq #(.N_ENC(N_ENC)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .num_i    (num_enc_i),
    .prime_o  (prime),
    .capture_o(capture),
    .upd_o    (upd),
    .idx_o    (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      step_q <= '0;
    end else begin
      if (prime || capture) prev_q <= cur_c;
      if (capture)          step_q <= step_c;
    end
  end

  // shared adder
  assign step_sel = step_q[{idx, 1'b0} +: 2];
  assign delta    = {{(PW-2){step_sel[1]}}, step_sel};
  assign sum      = pos_q[idx] + delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_ENC; k++) pos_q[k] <= '0;
    end else if (upd) begin
      pos_q[idx] <= sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      wr_o <= upd;
      if (upd) begin
        addr_o <= base_addr_i + AW'({idx, 2'b00});
        data_o <= sum;
      end
    end
  end
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int N_ENC = 16,
  parameter int AW    = 32,
  parameter int PW    = 32,
  parameter int CNT_W = 5,
  localparam int IDX_W = (N_ENC > 1) ? $clog2(N_ENC) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] num_enc_i,
  input logic [AW-1:0]    base_addr_i,
  input logic             wr_o,
  input logic [AW-1:0]    addr_o,
  input logic [PW-1:0]    data_o,
  input logic [2*N_ENC-1:0] step_q_i
);
  logic [AW-1:0]    off;
  logic [AW-1:0]    last_off;
  logic             in_range;
  logic [IDX_W-1:0] k_idx;
  logic [PW-1:0]    last_data [N_ENC];
  logic [PW-1:0]    diff;
  logic             bad_code;

  assign off      = addr_o - base_addr_i;
  assign last_off = AW'(num_enc_i) * AW'(4) - AW'(4);
  assign in_range = (off[1:0] == 2'b00) && ((off >> 2) < AW'(num_enc_i));
  assign k_idx    = IDX_W'(off >> 2);
  assign diff     = data_o - last_data[k_idx];

  always_comb begin
    bad_code = 1'b0;
    for (int k = 0; k < N_ENC; k++)
      if (step_q_i[2*k+1] && !step_q_i[2*k]) bad_code = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_ENC; k++) last_data[k] <= '0;
    end else if (wr_o && in_range) begin
      last_data[k_idx] <= data_o;
    end
  end

  a_r6_addr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> in_range);

  a_r6_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(wr_o)) |-> (off == $past(off) + AW'(4)));

  a_r7_gap_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && off == last_off) |=> !wr_o);

  a_r8_no_write_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_enc_i == '0) |-> !wr_o);

  a_r3_step_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_code);

  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && in_range) |-> (diff == '0 || diff == PW'(1) || diff == '1));
endmodule

bind quad_pos_counter qpc_checker #(
  .N_ENC(N_ENC), .AW(AW), .PW(PW), .CNT_W(CNT_W)
) i_qpc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .num_enc_i  (num_enc_i),
  .base_addr_i(base_addr_i),
  .wr_o       (wr_o),
  .addr_o     (addr_o),
  .data_o     (data_o),
  .step_q_i   (step_q)
);

// File: tb/test_quad_pos_counter.sv
module test_quad_pos_counter;
  localparam int N_ENC  = 16;
  localparam int STRIDE = 5;
  localparam int IN_W   = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] phase;
  logic [6:0]  first_bit;
  logic [4:0]  num_enc;
  logic [31:0] base_addr;
  logic        wr;
  logic [31:0] addr, data;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int it       = 0;

  int          st      [N_ENC];
  logic [31:0] exp_pos [N_ENC];
  logic [31:0] last_val[N_ENC];
  int          exp_k, writes, t0;
  bit          have_t0;

  always #5 clk = ~clk;

  quad_pos_counter i_quad_pos_counter (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .phase_i    (phase),
    .first_bit_i(first_bit),
    .num_enc_i  (num_enc),
    .base_addr_i(base_addr),
    .wr_o       (wr),
    .addr_o     (addr),
    .data_o     (data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // write monitor: checks order (R6) and spacing (R7)
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_k   = 0;
      writes  = 0;
      have_t0 = 0;
      for (int k = 0; k < N_ENC; k++) last_val[k] = 32'hDEAD_BEEF;
    end else if (wr) begin
      writes++;
      n_checks++;
      if (num_enc == 0 || addr != base_addr + 32'(4 * exp_k)) begin
        n_fail++;
        $display("FAIL R6: write addr %h expected %h", addr, base_addr + 32'(4 * exp_k));
      end else begin
        last_val[exp_k] = data;
        if (exp_k == 0) begin
          if (have_t0) begin
            n_checks++;
            if (cyc - t0 != int'(num_enc) + 1) begin
              n_fail++;
              $display("FAIL R7: period %0d expected %0d", cyc - t0, int'(num_enc) + 1);
            end
          end
          have_t0 = 1;
          t0      = cyc;
        end
        exp_k = (exp_k + 1 == int'(num_enc)) ? 0 : exp_k + 1;
      end
    end
  end

  function automatic logic gray_a(int g); return (g == 1) || (g == 2); endfunction
  function automatic logic gray_b(int g); return g >= 2; endfunction

  task automatic drive_bus();
    logic [95:0] raw;
    raw = {3{32'(32'h9E37_79B9 * 32'(it + 1))}};
    for (int k = 0; k < int'(num_enc); k++) begin
      raw[int'(first_bit) + k * STRIDE]     = gray_a(st[k]);
      raw[int'(first_bit) + k * STRIDE + 1] = gray_b(st[k]);
    end
    it++;
    phase = raw;
  endtask

  task automatic settle();
    repeat (3 * (int'(num_enc) + 1) + 6) @(negedge clk);
  endtask

  task automatic compare(string tag);
    for (int k = 0; k < int'(num_enc); k++) begin
      n_checks++;
      if (last_val[k] !== exp_pos[k]) begin
        n_fail++;
        $display("FAIL %s: enc %0d pos %h expected %h", tag, k, last_val[k], exp_pos[k]);
      end
    end
  endtask

  // move every encoder to new_st, update model by gray distance
  task automatic apply(int new_st[N_ENC], string tag);
    for (int k = 0; k < N_ENC; k++) begin
      int d;
      d = (new_st[k] - st[k] + 4) % 4;
      if (d == 1) exp_pos[k] = exp_pos[k] + 32'd1;
      else if (d == 3) exp_pos[k] = exp_pos[k] - 32'd1;
      st[k] = new_st[k];
    end
    @(negedge clk);
    drive_bus();
    settle();
    compare(tag);
  endtask

  task automatic start_cfg(int n, int fb, logic [31:0] base);
    @(negedge clk);
    rst_n     = 1'b0;
    num_enc   = 5'(n);
    first_bit = 7'(fb);
    base_addr = base;
    for (int k = 0; k < N_ENC; k++) begin
      st[k]      = 2;  // both phases high at reset release
      exp_pos[k] = '0;
    end
    drive_bus();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    compare("R4");
  endtask

  task automatic run_cfg(int n, int fb, logic [31:0] base);
    int nxt[N_ENC];
    start_cfg(n, fb, base);
    // R2/R3: every from/to gray pair per encoder
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        for (int k = 0; k < N_ENC; k++) nxt[k] = (f + k) % 4;
        apply(nxt, "R2");
        for (int k = 0; k < N_ENC; k++) nxt[k] = (f + k + ((t + k) % 4)) % 4;
        apply(nxt, "R3");
      end
    end
    // R1: only unused bus bits change
    for (int j = 0; j < 3; j++) begin
      for (int k = 0; k < N_ENC; k++) nxt[k] = st[k];
      apply(nxt, "R1");
    end
    // R5: long backward run
    for (int k = 0; k < N_ENC; k++) nxt[k] = 0;
    apply(nxt, "R5");
    for (int k = 0; k < N_ENC; k++) exp_pos[k] = exp_pos[k];
    for (int j = 0; j < 40; j++) begin
      for (int k = 0; k < N_ENC; k++) nxt[k] = (st[k] + 3) % 4;
      apply(nxt, "R5");
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    phase     = '0;
    first_bit = '0;
    num_enc   = '0;
    base_addr = '0;
    run_cfg(4, 3, 32'h0000_1000);
    run_cfg(16, 0, 32'h0000_0200);
    run_cfg(3, 20, 32'hFFFF_FFF8);
    // R8: no encoders, no writes
    start_cfg(0, 0, 32'h0000_0400);
    repeat (100) @(negedge clk);
    n_checks++;
    if (writes != 0) begin
      n_fail++;
      $display("FAIL R8: %0d writes expected 0", writes);
    end
    report();
  end

  initial begin
    wait (cyc > 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: cycle %0d expected completion", cyc);
    report();
  end
endmodule